// File: doc/BRIEF.md
# Error-Density Lock Monitor

This block decides whether a serial-link receiver should still be treated as locked. It looks at every received word, each flagged by a valid strobe plus decode-error and parity-error bits. A leaky up/down level rises by one on each bad word and falls by one on each clean word, and it never drops below zero. Lock is lost when the level climbs to a configurable ceiling. The trigger is therefore how dense the errors are, not how many errors have occurred in total.

When lock is lost, the lock output drops and a request for a fresh word-boundary search is raised. The request stays up until an external aligner signals that it has found a boundary. At that point the level is cleared and lock returns. If the search runs for a configurable number of cycles without success, a one-cycle request to reset the clock-recovery circuit is emitted. The search timer then restarts, so the reset is retried periodically until a boundary is found.

Top module: `lock_density_monitor`

## Requirements
- R1: After synchronous reset, `lock_o` is 1, `hunt_req_o` is 0 and `cdr_reset_o` is 0.
- R2: While locked, a word with `word_vld`=1 and either `dec_err`=1 or `par_err`=1 (or both) counts as bad and raises the level by one. When the level reaches `MAX_LEVEL` (default 16), `lock_o` goes 0 and `hunt_req_o` goes 1 in the cycle after that word is sampled.
- R3: While locked, a clean valid word lowers the level by one. Alternating bad and clean words never lose lock. In a repeating bad-bad-clean pattern, starting from level 0, lock is lost on the second bad word of the fifteenth triple.
- R4: The level is floored at zero. After any number of clean words from level 0, exactly `MAX_LEVEL` consecutive bad words are needed to lose lock.
- R5: Cycles with `word_vld`=0 leave the level unchanged, whatever the error flags are.
- R6: Once lock is lost, `lock_o` stays 0 and `hunt_req_o` stays 1 until `boundary_found` is sampled high.
- R7: While searching, received words and their error flags are ignored.
- R8: `boundary_found` sampled high while searching makes `lock_o` 1 and `hunt_req_o` 0 from the next cycle, with the level cleared to zero. `boundary_found` while locked has no effect, and the level is kept.
- R9: While searching, `cdr_reset_o` pulses high for one cycle after every `SEARCH_TIMEOUT` consecutive search cycles. With the search starting after clock edge P0, the pulses are visible after edges P(T), P(2T), and so on, where T is `SEARCH_TIMEOUT`.
- R10: `boundary_found` takes priority over timer expiry. No `cdr_reset_o` pulse follows a cycle in which `boundary_found` is sampled during a search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | A received word is present this cycle |
| dec_err | input | 1 | Decode error on the present word |
| par_err | input | 1 | Parity error on the present word |
| boundary_found | input | 1 | Aligner reports a valid word boundary |
| lock_o | output | 1 | Link considered locked |
| hunt_req_o | output | 1 | Word-boundary search requested |
| cdr_reset_o | output | 1 | One-cycle clock-recovery reset request |

## Verification
A wrong error level shows up at the ports only as a shifted moment of lock loss. A level that is one too high or fails to floor at zero drops `lock_o` one or more words early. A level that is not cleared on relock drops it too soon on the next burst. The search timer is observable only through the exact cycle of each `cdr_reset_o` pulse. For that reason the bench compares all three outputs against a behavioural model on every cycle, so that a one-cycle or one-word slip is reported immediately. It also sweeps the relock instant across the whole timeout window to hit the coincidence with expiry.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

    typedef enum logic [0:0] {
        LM_TRACK = 1'b0,
        LM_HUNT  = 1'b1
    } lm_state_e;

    typedef struct packed {
        logic vld;
        logic dec_err;
        logic par_err;
    } lm_word_s;

    function automatic logic word_is_bad(lm_word_s w);
        return w.dec_err | w.par_err;
    endfunction

endpackage

// File: rtl/lm_density_filter.sv
module lm_density_filter
    import lockmon_pkg::*;
#(
    parameter int unsigned MAX_LEVEL = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     clr,
    input  lm_word_s word,
    output logic     trip_o
);
    localparam int unsigned LW = $clog2(MAX_LEVEL + 1);
    localparam logic [LW-1:0] TRIP_AT = LW'(MAX_LEVEL - 1);

    logic [LW-1:0] level;
    logic          bad;
    logic          step_up;
    logic          step_dn;

    always_comb begin
        bad     = word_is_bad(word);
        step_up = en && word.vld && bad;
        step_dn = en && word.vld && !bad && (level != '0);
        trip_o  = step_up && (level == TRIP_AT);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level <= '0;
        end else if (step_up) begin
            level <= level + 1'b1;
        end else if (step_dn) begin
            level <= level - 1'b1;
        end
    end

    // R2: a bad word while tracking raises the level by one
    a_r2_rise: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && word.vld && (word.dec_err || word.par_err))
        |=> level == $past(level) + 1'b1);

    // R4: clean word at zero keeps the level at zero
    a_r4_floor: assert property (@(posedge clk) disable iff (rst)
        (en && !clr && word.vld && !word.dec_err && !word.par_err && level == '0)
        |=> level == '0);

    // R5: no strobe, no change
    a_r5_idle: assert property (@(posedge clk) disable iff (rst)
        (!word.vld && !clr) |=> $stable(level));

    // R7: level frozen while searching
    a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(level));

endmodule

// File: rtl/lm_search_timer.sv
module lm_search_timer #(
    parameter int unsigned SEARCH_TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expire_o
);
    localparam int unsigned TW = $clog2(SEARCH_TIMEOUT);
    localparam logic [TW-1:0] LAST = TW'(SEARCH_TIMEOUT - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt      <= '0;
            expire_o <= 1'b0;
        end else if (cnt == LAST) begin
            cnt      <= '0;
            expire_o <= 1'b1;
        end else begin
            cnt      <= cnt + 1'b1;
            expire_o <= 1'b0;
        end
    end

    // R9: the reset request is a single-cycle pulse
    a_r9_single: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !expire_o);

endmodule

// File: rtl/lock_density_monitor.sv
module lock_density_monitor
    import lockmon_pkg::*;
#(
    parameter int unsigned MAX_LEVEL      = 16,
    parameter int unsigned SEARCH_TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic word_vld,
    input  logic dec_err,
    input  logic par_err,
    input  logic boundary_found,
    output logic lock_o,
    output logic hunt_req_o,
    output logic cdr_reset_o
);
    lm_state_e state;
    lm_word_s  word;
    logic      trip;
    logic      relock;
    logic      expire;

    always_comb begin
        word.vld     = word_vld;
        word.dec_err = dec_err;
        word.par_err = par_err;
        relock       = (state == LM_HUNT) && boundary_found;
    end

    lm_density_filter #(.MAX_LEVEL(MAX_LEVEL)) filt_i (
        .clk    (clk),
        .rst    (rst),
        .en     (state == LM_TRACK),
        .clr    (relock),
        .word   (word),
        .trip_o (trip)
    );

    lm_search_timer #(.SEARCH_TIMEOUT(SEARCH_TIMEOUT)) tmr_i (
        .clk      (clk),
        .rst      (rst),
        .run      ((state == LM_HUNT) && !boundary_found),
        .expire_o (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= LM_TRACK;
        end else begin
            case (state)
                LM_TRACK: if (trip)           state <= LM_HUNT;
                LM_HUNT:  if (boundary_found) state <= LM_TRACK;
                default:                      state <= LM_TRACK;
            endcase
        end
    end

    always_comb begin
        lock_o      = (state == LM_TRACK);
        hunt_req_o  = (state == LM_HUNT);
        cdr_reset_o = expire;
    end

    // R6: search is held until a boundary is reported
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (hunt_req_o && !boundary_found) |=> (hunt_req_o && !lock_o));

    // R8: boundary found during search restores lock
    a_r8_relock: assert property (@(posedge clk) disable iff (rst)
        (hunt_req_o && boundary_found) |=> (lock_o && !hunt_req_o));

    // R9: clock-recovery reset only while searching
    a_r9_in_hunt: assert property (@(posedge clk) disable iff (rst)
        cdr_reset_o |-> hunt_req_o);

    // R10: relock suppresses a coincident timer expiry
    a_r10_prio: assert property (@(posedge clk) disable iff (rst)
        (hunt_req_o && boundary_found) |=> !cdr_reset_o);

endmodule

// File: tb/lock_density_monitor_tb_top.sv
module lock_density_monitor_tb_top;
    localparam int MAXL = 16;
    localparam int TOUT = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_vld = 1'b0, dec_err = 1'b0, par_err = 1'b0, boundary_found = 1'b0;
    logic lock_o, hunt_req_o, cdr_reset_o;

    always #4 clk = ~clk;

    lock_density_monitor #(.MAX_LEVEL(MAXL), .SEARCH_TIMEOUT(TOUT)) dut_i (
        .clk(clk), .rst(rst), .word_vld(word_vld), .dec_err(dec_err),
        .par_err(par_err), .boundary_found(boundary_found),
        .lock_o(lock_o), .hunt_req_o(hunt_req_o), .cdr_reset_o(cdr_reset_o)
    );

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";
    bit comparing = 1'b0;
    bit finished = 1'b0;

    // behavioural reference model
    int  m_lvl = 0;
    int  m_t = 0;
    bit  m_hunt = 1'b0;
    bit  m_cdr = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_lvl = 0; m_t = 0; m_hunt = 1'b0; m_cdr = 1'b0;
        end else if (!m_hunt) begin
            m_cdr = 1'b0;
            if (word_vld) begin
                if (dec_err || par_err) m_lvl = m_lvl + 1;
                else if (m_lvl > 0)     m_lvl = m_lvl - 1;
            end
            if (m_lvl >= MAXL) begin m_hunt = 1'b1; m_t = 0; end
        end else if (boundary_found) begin
            m_hunt = 1'b0; m_lvl = 0; m_t = 0; m_cdr = 1'b0;
        end else if (m_t == TOUT - 1) begin
            m_t = 0; m_cdr = 1'b1;
        end else begin
            m_t = m_t + 1; m_cdr = 1'b0;
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (comparing && !finished) begin
            chk(cur_req, "lock_o (model)", lock_o, !m_hunt);
            chk(cur_req, "hunt_req_o (model)", hunt_req_o, m_hunt);
            chk(cur_req, "cdr_reset_o (model)", cdr_reset_o, m_cdr);
        end
    end

    task automatic step(logic v, logic d, logic p, logic a);
        @(negedge clk);
        word_vld = v; dec_err = d; par_err = p; boundary_found = a;
    endtask

    task automatic idle_check(string req, logic exp_lock, logic exp_cdr);
        step(0, 0, 0, 0);
        #1;
        chk(req, "lock_o", lock_o, exp_lock);
        chk(req, "hunt_req_o", hunt_req_o, !exp_lock);
        chk(req, "cdr_reset_o", cdr_reset_o, exp_cdr);
    endtask

    task automatic relock_and_drain();
        step(0, 0, 0, 1);
        step(0, 0, 0, 0);
    endtask

    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        cur_req = "R1";
        chk("R1", "lock_o", lock_o, 1'b1);
        chk("R1", "hunt_req_o", hunt_req_o, 1'b0);
        chk("R1", "cdr_reset_o", cdr_reset_o, 1'b0);
        comparing = 1'b1;

        // R4: floor at zero, then exactly MAXL bad words
        cur_req = "R4";
        for (int i = 0; i < 50; i++) step(1, 0, 0, 0);
        for (int i = 0; i < MAXL - 1; i++) step(1, 1, 0, 0);
        idle_check("R4", 1'b1, 1'b0);
        cur_req = "R2";
        step(1, 0, 1, 0);
        idle_check("R2", 1'b0, 1'b0);
        relock_and_drain();

        // R2: mixed flag kinds
        for (int i = 0; i < MAXL - 1; i++) step(1, i[0], !i[0] | i[1], 0);
        idle_check("R2", 1'b1, 1'b0);
        step(1, 1, 1, 0);
        idle_check("R2", 1'b0, 1'b0);
        relock_and_drain();

        // R5: flags without strobe are ignored
        cur_req = "R5";
        for (int i = 0; i < 40; i++) step(0, 1, 1, 0);
        for (int i = 0; i < MAXL - 1; i++) step(1, 1, 0, 0);
        for (int i = 0; i < 30; i++) step(0, 1, 0, 0);
        idle_check("R5", 1'b1, 1'b0);
        step(1, 1, 0, 0);
        idle_check("R5", 1'b0, 1'b0);
        relock_and_drain();

        // R3: density dependence
        cur_req = "R3";
        for (int i = 0; i < 200; i++) step(1, i[0], 0, 0);
        idle_check("R3", 1'b1, 1'b0);
        for (int i = 0; i < 100; i++) step(1, 0, 0, 0);
        for (int i = 0; i < 14; i++) begin
            step(1, 1, 0, 0); step(1, 0, 1, 0); step(1, 0, 0, 0);
        end
        idle_check("R3", 1'b1, 1'b0);
        step(1, 1, 0, 0); step(1, 1, 0, 0);
        idle_check("R3", 1'b0, 1'b0);

        // R6 and R7: search holds, words ignored
        cur_req = "R7";
        for (int i = 0; i < 20; i++) step(1, 1, 1, 0);
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0);
        cur_req = "R6";
        step(0, 0, 0, 0); #1;
        chk("R6", "hunt_req_o", hunt_req_o, 1'b1);
        chk("R6", "lock_o", lock_o, 1'b0);
        relock_and_drain();
        cur_req = "R8";
        for (int i = 0; i < MAXL - 1; i++) step(1, 1, 0, 0);
        idle_check("R8", 1'b1, 1'b0);
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0);

        // R8: boundary_found while locked keeps the level
        for (int i = 0; i < 10; i++) step(1, 1, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1);
        for (int i = 0; i < MAXL - 10; i++) step(1, 1, 0, 0);
        idle_check("R8", 1'b0, 1'b0);

        // R9: periodic clock-recovery reset
        cur_req = "R9";
        relock_and_drain();
        for (int i = 0; i < MAXL - 1; i++) step(1, 1, 0, 0);
        step(1, 1, 0, 0);
        idle_check("R9", 1'b0, 1'b0);
        for (int i = 0; i < TOUT - 2; i++) step(0, 0, 0, 0);
        idle_check("R9", 1'b0, 1'b0);
        idle_check("R9", 1'b0, 1'b1);
        idle_check("R9", 1'b0, 1'b0);
        for (int i = 0; i < TOUT - 2; i++) step(0, 0, 0, 0);
        idle_check("R9", 1'b0, 1'b1);

        // R10: relock at every offset of the timeout window
        cur_req = "R10";
        for (int k = 0; k < TOUT + 6; k++) begin
            relock_and_drain();
            for (int i = 0; i < MAXL; i++) step(1, 1, 1, 0);
            for (int i = 0; i < k; i++) step(0, 0, 0, 0);
            step(0, 0, 0, 1);
            idle_check("R10", 1'b1, 1'b0);
        end

        // mixed traffic against the model
        cur_req = "R2";
        for (int i = 0; i < 4000; i++) begin
            automatic int r = $urandom % 100;
            step(($urandom % 4) != 0, r < 12, (r % 9) == 0, ($urandom % 60) == 0);
        end
        step(0, 0, 0, 0);
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule